// File: doc/BRIEF.md
# Serial GPIO backplane indicator receiver

This block sits on the drive backplane and listens to a four-wire serial GPIO link driven by a host adapter. It samples the link clock, load and data-out lines with a much faster local system clock. It finds frame starts from the load line and captures a four-bit vendor code from the load line. It splits the data-out stream into three indicator bits per drive slot and holds them in per-slot activity, locate and fail outputs. It also drives the data-in line back to the host, one presence bit per slot followed by two low bits.

The host may send a frame that stops before the last slot, or one that runs past it. The link clock may stop at any point and may rest at either level. A watchdog clears every indicator when all three host lines stay high for a programmable number of system clock cycles. The local clock must run at least twenty times faster than the link clock. The link inputs are resynchronised inside the block.

Top module: `sgpio_led_target`

## Requirements
- R1: A frame starts at a link clock rising edge where load is high, provided load was low at each of at least the 5 preceding rising edges. A high load after only 4 low edges does not restart the frame.
- R2: The load values seen at the 4 link clock falling edges after a frame start form the vendor code. The first falling edge gives bit 0 and the fourth gives bit 3. The code updates only after the fourth edge.
- R3: Data-out is sampled at each link clock rising edge after the start edge. Stream bit 3k+0 is slot k activity, bit 3k+1 is slot k locate and bit 3k+2 is slot k fail, with slot 0 first.
- R4: A slot's three outputs change together, only once its third bit has been sampled, and never on the first or second bit.
- R5: Slots not reached by a short frame keep their previous values. Bits after the last slot's third bit are ignored until the next frame start.
- R6: sdin_o shows the value for the stream bit that the next rising edge covers. At bit 3k+0 it shows presence of slot k. At bits 3k+1 and 3k+2 it is low. It is high outside a frame and after the last slot.
- R7: When link clock, load and data-out have all been high for TIMEOUT_CYC system clocks, every activity, locate and fail output is cleared. They stay cleared while the lines remain high. A shorter high spell changes nothing, and the vendor code is kept.
- R8: A link clock halted for any time at either level, inside or between frames, does not move the slot position.
- R9: After reset all indicators and the vendor code are 0, and sdin_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | local system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| sclk_i | input | 1 | link clock from host, asynchronous |
| sload_i | input | 1 | link load line from host, asynchronous |
| sdout_i | input | 1 | link data line from host, asynchronous |
| present_i | input | NUM_SLOTS | drive-present flag per slot |
| act_o | output | NUM_SLOTS | activity indicator per slot |
| loc_o | output | NUM_SLOTS | locate indicator per slot |
| fail_o | output | NUM_SLOTS | fail indicator per slot |
| vendor_o | output | 4 | vendor code from the last frame |
| sdin_o | output | 1 | value to drive on the link data-in line |

## Verification
The bench builds the block with NUM_SLOTS = 4 and TIMEOUT_CYC = 300. Four slots let a few dozen link clock cycles cover a full frame, a frame that stops after two slots and one that overruns the last slot. The short timeout brings both an expiring and a non-expiring all-high spell within a few hundred system clocks. Link clock pauses at both levels and a load pulse after only four low edges are mixed into the same run.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;

  typedef struct packed {
    logic act;
    logic loc;
    logic fail;
  } led_t;

  localparam int BITS_PER_SLOT = 3;
  localparam int NIB_BITS      = 4;

  // position within a slot's three bits: 0 activity, 1 locate, 2 fail
  function automatic logic is_last_bit(input logic [1:0] pos);
    return pos == 2'd2;
  endfunction

  // value for the return line at a given slot position
  function automatic logic sdin_bit(input logic active, input logic [1:0] pos,
                                    input logic present);
    if (!active) return 1'b1;
    return (pos == 2'd0) ? present : 1'b0;
  endfunction

endpackage

// File: rtl/sgpio_sync.sv
module sgpio_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign q_o    = sync_q;
  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/sgpio_idle_wd.sv
module sgpio_idle_wd #(
  parameter int TIMEOUT_CYC = 12_800_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic all_hi_i,
  output logic blank_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!all_hi_i)     cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign blank_o = (cnt_q == LIMIT);

  // R7: the idle counter never runs past its limit
  p_wd_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LIMIT && all_hi_i) |=> (cnt_q == LIMIT));
  // R7: any low line restarts the count
  p_wd_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !all_hi_i |=> (cnt_q == '0));
endmodule

// File: rtl/sgpio_frame.sv
module sgpio_frame
  import sgpio_pkg::*;
#(
  parameter int NUM_SLOTS = 36,
  parameter int MIN_LOW   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_rise_i,
  input  logic                 clk_fall_i,
  input  logic                 load_i,
  input  logic                 dout_i,
  input  logic [NUM_SLOTS-1:0] present_i,
  output logic                 frame_start_o,
  output logic                 slot_wr_o,
  output logic [((NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1)-1:0] wr_slot_o,
  output led_t                 wr_led_o,
  output logic [3:0]           vendor_o,
  output logic                 sdin_o
);
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int LW = $clog2(MIN_LOW + 1);
  localparam logic [LW-1:0] LOW_SAT = LW'(MIN_LOW);
  localparam logic [SW-1:0] LAST_SLOT = SW'(NUM_SLOTS - 1);

  logic [LW-1:0] low_cnt_q;
  logic          active_q;
  logic [1:0]    pos_q;
  logic [SW-1:0] slot_q;
  logic [1:0]    part_q;
  logic [2:0]    nib_cnt_q;
  logic [2:0]    nib_sh_q;
  logic [3:0]    vendor_q;
  logic          data_take;

  assign frame_start_o = clk_rise_i && load_i && (low_cnt_q >= LOW_SAT);
  assign data_take     = clk_rise_i && !frame_start_o && active_q;
  assign slot_wr_o     = data_take && is_last_bit(pos_q);
  assign wr_slot_o     = slot_q;
  assign wr_led_o      = '{act: part_q[0], loc: part_q[1], fail: dout_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      active_q  <= 1'b0;
      pos_q     <= 2'd0;
      slot_q    <= '0;
      part_q    <= 2'b00;
      nib_cnt_q <= 3'd4;
      nib_sh_q  <= 3'b000;
      vendor_q  <= 4'h0;
    end else begin
      if (clk_rise_i) begin
        if (load_i)                  low_cnt_q <= '0;
        else if (low_cnt_q != LOW_SAT) low_cnt_q <= low_cnt_q + 1'b1;
      end
      if (frame_start_o) begin
        active_q  <= 1'b1;
        pos_q     <= 2'd0;
        slot_q    <= '0;
        nib_cnt_q <= 3'd0;
      end else if (data_take) begin
        if (is_last_bit(pos_q)) begin
          pos_q <= 2'd0;
          if (slot_q == LAST_SLOT) active_q <= 1'b0;
          else                     slot_q   <= slot_q + 1'b1;
        end else begin
          part_q[pos_q[0]] <= dout_i;
          pos_q            <= pos_q + 2'd1;
        end
      end
      if (clk_fall_i && nib_cnt_q < 3'd4) begin
        nib_cnt_q <= nib_cnt_q + 3'd1;
        if (nib_cnt_q == 3'd3) vendor_q <= {load_i, nib_sh_q};
        else                   nib_sh_q[nib_cnt_q[1:0]] <= load_i;
      end
    end
  end

  assign vendor_o = vendor_q;
  assign sdin_o   = sdin_bit(active_q, pos_q, present_i[slot_q]);

  // R1: a start always re-arms the stream at slot 0, bit 0
  p_start_rearm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> (active_q && pos_q == 2'd0 && slot_q == '0));
  // R2: vendor code only moves on the fourth falling edge of a frame
  p_vendor_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_fall_i && nib_cnt_q == 3'd3) |=> $stable(vendor_q));
  // R5: the last slot's third bit closes the stream
  p_stop_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_wr_o && slot_q == LAST_SLOT) |=> !active_q);
  // R8: with no link clock edge the slot position holds
  p_pause_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_rise_i || clk_fall_i) |=> ($stable(slot_q) && $stable(pos_q)));
endmodule

// File: rtl/sgpio_led_target.sv
module sgpio_led_target
  import sgpio_pkg::*;
#(
  parameter int NUM_SLOTS   = 36,
  parameter int TIMEOUT_CYC = 12_800_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_i,
  input  logic                 sload_i,
  input  logic                 sdout_i,
  input  logic [NUM_SLOTS-1:0] present_i,
  output logic [NUM_SLOTS-1:0] act_o,
  output logic [NUM_SLOTS-1:0] loc_o,
  output logic [NUM_SLOTS-1:0] fail_o,
  output logic [3:0]           vendor_o,
  output logic                 sdin_o
);
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [2:0]    line_q, line_rise, line_fall;
  logic          frame_start, slot_wr, blank;
  logic [SW-1:0] wr_slot;
  led_t          wr_led;
  logic [NUM_SLOTS-1:0] act_q, loc_q, fail_q;

  // bit 2 link clock, bit 1 load, bit 0 data-out
  sgpio_sync #(.W(3)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i({sclk_i, sload_i, sdout_i}),
    .q_o(line_q), .rise_o(line_rise), .fall_o(line_fall)
  );

  sgpio_frame #(.NUM_SLOTS(NUM_SLOTS), .MIN_LOW(5)) i_frame (
    .clk(clk), .rst_n(rst_n),
    .clk_rise_i(line_rise[2]), .clk_fall_i(line_fall[2]),
    .load_i(line_q[1]), .dout_i(line_q[0]), .present_i(present_i),
    .frame_start_o(frame_start), .slot_wr_o(slot_wr),
    .wr_slot_o(wr_slot), .wr_led_o(wr_led),
    .vendor_o(vendor_o), .sdin_o(sdin_o)
  );

  sgpio_idle_wd #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_wd (
    .clk(clk), .rst_n(rst_n), .all_hi_i(&line_q), .blank_o(blank)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q[s]  <= 1'b0;
        loc_q[s]  <= 1'b0;
        fail_q[s] <= 1'b0;
      end else if (blank) begin
        act_q[s]  <= 1'b0;
        loc_q[s]  <= 1'b0;
        fail_q[s] <= 1'b0;
      end else if (slot_wr && wr_slot == SW'(s)) begin
        act_q[s]  <= wr_led.act;
        loc_q[s]  <= wr_led.loc;
        fail_q[s] <= wr_led.fail;
      end
    end
  end

  assign act_o  = act_q;
  assign loc_o  = loc_q;
  assign fail_o = fail_q;

  // R4: indicators move only on a slot completion or a timeout
  p_hold_unless_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ({act_q, loc_q, fail_q} != $past({act_q, loc_q, fail_q})) |-> $past(slot_wr || blank));
  // R7: a timeout leaves every indicator dark
  p_blank_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> (act_q == '0 && loc_q == '0 && fail_q == '0));
  // R1: a frame start never coincides with a slot write
  p_start_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !slot_wr);
endmodule

// File: tb/test_sgpio_led_target.sv
`timescale 1ns/1ps
module test_sgpio_led_target;
  localparam int N = 4;
  localparam int T = 300;
  localparam int NB = 3 * N;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic sclk = 1'b0, sload = 1'b0, sdout = 1'b0;
  logic [N-1:0] present = '0;
  logic [N-1:0] act, loc, fail;
  logic [3:0] vendor;
  logic sdin;

  sgpio_led_target #(.NUM_SLOTS(N), .TIMEOUT_CYC(T)) i_sgpio_led_target (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sload_i(sload), .sdout_i(sdout),
    .present_i(present), .act_o(act), .loc_o(loc), .fail_o(fail),
    .vendor_o(vendor), .sdin_o(sdin)
  );

  int n_chk = 0, n_fail = 0;
  string tag = "R9";

  // behavioural reference
  bit [N-1:0] e_act, e_loc, e_fail;
  bit [3:0] e_ven, ven_tmp;
  bit [2:0] tmp;
  int lowrun, bitno, nib, quiet, hicnt;
  bit inf, p_sclk;
  bit [N+2:0] p_in;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic bit exp_sdin();
    if (inf && bitno < NB) return (bitno % 3 == 0) ? present[bitno/3] : 1'b0;
    return 1'b1;
  endfunction

  task automatic model_rise();
    bit start;
    start = sload && lowrun >= 5;
    lowrun = sload ? 0 : ((lowrun < 5) ? lowrun + 1 : 5);
    if (start) begin
      inf = 1; bitno = 0; nib = 0;
    end else if (inf && bitno < NB) begin
      tmp[bitno % 3] = sdout;
      if (bitno % 3 == 2) begin
        e_act[bitno/3] = tmp[0]; e_loc[bitno/3] = tmp[1]; e_fail[bitno/3] = tmp[2];
      end
      bitno++;
    end
  endtask

  task automatic model_fall();
    if (nib < 4) begin
      ven_tmp[nib] = sload;
      nib++;
      if (nib == 4) e_ven = ven_tmp;
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      e_act = '0; e_loc = '0; e_fail = '0; e_ven = '0; inf = 0;
      lowrun = 0; bitno = 0; nib = 4; quiet = 0; hicnt = 0;
      p_sclk = sclk; p_in = {sclk, sload, sdout, present};
    end else begin
      if ({sclk, sload, sdout, present} != p_in) quiet = 0;
      else if (quiet < 1000) quiet++;
      if (sclk && sload && sdout) hicnt++; else hicnt = 0;
      if (sclk && !p_sclk) model_rise();
      if (!sclk && p_sclk) model_fall();
      if (hicnt >= T + 3) begin e_act = '0; e_loc = '0; e_fail = '0; end
      p_in = {sclk, sload, sdout, present}; p_sclk = sclk;
      if (quiet >= 4 && !(hicnt > T && hicnt < T + 6)) begin
        chk({tag, " act"}, act, e_act);
        chk({tag, " loc"}, loc, e_loc);
        chk({tag, " fail"}, fail, e_fail);
        chk("R2 vendor", vendor, e_ven);
        chk("R6 sdin", sdin, exp_sdin());
      end
    end
  end

  task automatic seg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one link clock period: rising edge samples rl/d, next falling edge samples fl
  task automatic cyc(input logic rl, input logic fl, input logic d, input int hold = 6);
    sload = rl; sdout = d; seg(hold);
    sclk = 1'b1; seg(hold);
    sload = fl; seg(hold);
    sclk = 1'b0; seg(hold);
  endtask

  task automatic frame(input logic [3:0] v, input logic [31:0] bits, input int nbits,
                       input int pre = 5, input int hold = 6);
    repeat (pre) cyc(0, 0, 0);
    cyc(1, v[0], 0);
    for (int k = 0; k < nbits; k++) cyc(0, (k < 3) ? v[k+1] : 1'b0, bits[k], hold);
  endtask

  initial begin
    seg(6); rst_n = 1'b1; seg(3);
    // R9: state after reset
    chk("R9 act", act, '0); chk("R9 loc", loc, '0); chk("R9 fail", fail, '0);
    chk("R9 vendor", vendor, 4'h0); chk("R9 sdin", sdin, 1'b1);

    present = 4'b1010;
    tag = "R3"; frame(4'b1011, 32'h0000_0B6D, NB);
    seg(2);
    chk("R3 slot0 act", act[0], 1'b1); chk("R3 slot0 fail", fail[0], 1'b1);
    chk("R2 vendor code", vendor, 4'b1011);
    tag = "R5"; frame(4'b0110, 32'h0000_0012, 6);
    seg(2);
    chk("R5 slot3 kept", {act[3], loc[3], fail[3]}, {e_act[3], e_loc[3], e_fail[3]});
    tag = "R5"; frame(4'b0001, 32'h0003_F5A5, NB + 6);
    tag = "R4"; frame(4'b1100, 32'h0000_0924, NB, 5, 3);
    tag = "R1";
    cyc(1, 0, 0); repeat (4) cyc(0, 0, 1); cyc(1, 1, 0);
    for (int k = 0; k < NB; k++) cyc(0, 0, k[0]);
    present = 4'b0101;
    tag = "R8";
    repeat (5) cyc(0, 0, 0);
    cyc(1, 1, 0);
    for (int k = 0; k < NB; k++) begin
      cyc(0, 0, ~k[1], 6);
      if (k == 4) begin sclk = 1'b1; seg(150); sclk = 1'b0; seg(6); end
      else if (k == 7) seg(150);
    end
    sclk = 1'b1; seg(120); sclk = 1'b0; seg(6);
    tag = "R6"; frame(4'b0101, 32'h0000_0FFF, NB);
    tag = "R7";
    sload = 1'b1; sdout = 1'b1; seg(6); sclk = 1'b1; seg(T - 60);
    chk("R7 short spell keeps act", act, e_act);
    sload = 1'b0; seg(6); sclk = 1'b0; seg(6);
    sload = 1'b1; seg(6); sclk = 1'b1; seg(T + 40);
    chk("R7 cleared act", act, '0); chk("R7 cleared loc", loc, '0);
    chk("R7 cleared fail", fail, '0); chk("R7 vendor kept", vendor, e_ven);
    sload = 1'b0; sdout = 1'b0; seg(6); sclk = 1'b0; seg(6);
    tag = "R3"; frame(4'b1001, 32'h0000_0A5A, NB);
    seg(10);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    seg(150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog run did not complete");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule